// File: doc/BRIEF.md
# Timer start/stop control and status register

This block is the single 8-bit control/status register that sits in front of a down-counting timer core. Software writes a run request into it and reads back whether the counter is actually running. A running status bit copies the request only when the count-source tick arrives, so the counter always starts and stops on a tick boundary. A separate write-only stop bit halts the timer at once, without waiting for a tick, and sends a one-cycle strobe that returns the timer's pulse output to its idle level.

Two sticky event flags record that the counter core reported an underflow or a completed edge measurement. Software clears a flag by writing 0 to it. Writing 1 to a flag leaves it as it is, so a plain write of a saved value cannot wipe out an event that arrived in between. The counter core supplies the tick, underflow and edge pulses and receives the count-enable.

Top module: `tmr_ctl_reg`

## Requirements
- R1: After reset, every bit of the read data is 0, and count_en and pout_reset are 0.
- R2: A write loads bit 0 (run request) from wdata[0]. Bit 0 reads back the stored request.
- R3: Bit 1 (running status) is read-only. On a cycle with tick high, it takes the value the run request held before any write in that same cycle, and it is visible on the next cycle. Between ticks it holds its value, and a write to bit 1 has no effect.
- R4: A write with wdata[2]=1 (forced stop) clears both the run request and the running status on the next cycle, whatever wdata[0] and tick are. Bit 2 always reads 0.
- R5: pout_reset is high for exactly the one cycle that follows a forced-stop write, and low at all other times.
- R6: An edge_evt pulse sets bit 4 (edge flag) on the next cycle. The flag stays set until software clears it.
- R7: An underflow_evt pulse sets bit 5 (underflow flag) on the next cycle. The flag stays set until software clears it.
- R8: A write with a 0 in bit 4 or bit 5 clears that flag. A write with a 1 in bit 4 or bit 5 leaves that flag unchanged.
- R9: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R10: Bits 3, 6 and 7 always read 0, and writes to them are ignored.
- R11: count_en always equals the running status (bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| tick | input | 1 | Count-source tick, a one-cycle pulse |
| edge_evt | input | 1 | Edge measurement complete, from the counter core |
| underflow_evt | input | 1 | Counter underflow, from the counter core |
| rdata | output | 8 | Register read value |
| count_en | output | 1 | Counter may decrement on ticks while high |
| pout_reset | output | 1 | One-cycle strobe that resets the timer's pulse output |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is a hardware event and a software write that clears the same sticky flag. The second is a run-request write and a tick, together with a forced stop that arrives alongside a start request. The bench raises an event pulse in the exact cycle of a write of zero and expects the flag to read as set afterwards. It also drives a start write on a tick and expects the status to stay 0 until the following tick. A write with both start and stop set must leave the register idle and produce the output-reset strobe.

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  logic       edge_evt,
  input  logic       underflow_evt,
  output logic [7:0] rdata,
  output logic       count_en,
  output logic       pout_reset
);
  localparam int RUN_B  = 0;
  localparam int STOP_B = 2;
  localparam int EDGE_B = 4;
  localparam int UNF_B  = 5;

  logic run_req, run_sts, edge_flg, unf_flg, pout_q;
  logic force_stop;

  assign force_stop = wr_en & wdata[STOP_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req  <= 1'b0;
      run_sts  <= 1'b0;
      edge_flg <= 1'b0;
      unf_flg  <= 1'b0;
      pout_q   <= 1'b0;
    end else begin
      pout_q <= force_stop;
      if (force_stop) begin
        run_req <= 1'b0;
        run_sts <= 1'b0;
      end else begin
        if (wr_en) run_req <= wdata[RUN_B];
        if (tick)  run_sts <= run_req;
      end
      if (edge_evt)                       edge_flg <= 1'b1;
      else if (wr_en && !wdata[EDGE_B])   edge_flg <= 1'b0;
      if (underflow_evt)                  unf_flg  <= 1'b1;
      else if (wr_en && !wdata[UNF_B])    unf_flg  <= 1'b0;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[7:6], wdata[3], wdata[1]};

  assign rdata      = {2'b00, unf_flg, edge_flg, 1'b0, 1'b0, run_sts, run_req};
  assign count_en   = run_sts;
  assign pout_reset = pout_q;
endmodule

module tmr_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       tick,
  input logic       edge_evt,
  input logic       underflow_evt,
  input logic [7:0] rdata,
  input logic       count_en,
  input logic       pout_reset
);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && wdata[2])) |=> $stable(rdata[1]));
  a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && wdata[2])) |=> (rdata[1] == $past(rdata[0])));
  a_r4_force: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2]) |=> (rdata[1:0] == 2'b00));
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2]) |=> pout_reset);
  a_r5_only: assert property (@(posedge clk) disable iff (!rst_n)
    pout_reset |-> $past(wr_en && wdata[2]));
  a_r6_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> rdata[4]);
  a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |=> rdata[5]);
  a_r8_edge_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4] && !(wr_en && !wdata[4])) |=> rdata[4]);
  a_r8_unf_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[5] && !(wr_en && !wdata[5])) |=> rdata[5]);
  a_r10_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[3] == 1'b0) && (rdata[7:6] == 2'b00) && (rdata[2] == 1'b0));
  a_r11_enable: assert property (@(posedge clk) disable iff (!rst_n)
    count_en == rdata[1]);
endmodule

bind tmr_ctl_reg tmr_ctl_reg_chk u_chk (.*);

// File: tb/tb_tmr_ctl_reg.sv
`timescale 1ns/1ps
module tb_tmr_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tick = 1'b0;
  logic       edge_evt = 1'b0;
  logic       underflow_evt = 1'b0;
  logic [7:0] rdata;
  logic       count_en;
  logic       pout_reset;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tmr_ctl_reg dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample at the following falling edge.
  task automatic cyc(input logic w, input logic [7:0] d, input logic t,
                     input logic e, input logic u);
    wr_en = w; wdata = d; tick = t; edge_evt = e; underflow_evt = u;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00; tick = 1'b0; edge_evt = 1'b0; underflow_evt = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 count_en", {7'd0, count_en}, 8'h00);
    chk("R1 pout_reset", {7'd0, pout_reset}, 8'h00);
  endtask

  task automatic t_start_stop;
    cyc(1, 8'h31, 0, 0, 0);
    chk("R2 request set", rdata, 8'h01);
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, 0);
    chk("R3 no tick holds status", rdata, 8'h01);
    cyc(0, 8'h00, 1, 0, 0);
    chk("R3 status on tick", rdata, 8'h03);
    chk("R11 count_en high", {7'd0, count_en}, 8'h01);
    cyc(1, 8'h30, 0, 0, 0);
    chk("R2 request cleared, R3 status held", rdata, 8'h02);
    cyc(0, 8'h00, 1, 0, 0);
    chk("R3 status clears on tick", rdata, 8'h00);
    chk("R11 count_en low", {7'd0, count_en}, 8'h00);
  endtask

  task automatic t_write_with_tick;
    cyc(1, 8'h31, 1, 0, 0);
    chk("R3 tick uses old request", rdata, 8'h01);
    cyc(0, 8'h00, 1, 0, 0);
    chk("R3 next tick starts", rdata, 8'h03);
  endtask

  task automatic t_force_stop;
    cyc(1, 8'h34, 0, 0, 0);
    chk("R4 forced stop clears", rdata, 8'h00);
    chk("R5 strobe after stop", {7'd0, pout_reset}, 8'h01);
    cyc(0, 8'h00, 0, 0, 0);
    chk("R5 strobe one cycle", {7'd0, pout_reset}, 8'h00);
    cyc(1, 8'h31, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0);
    cyc(1, 8'h35, 1, 0, 0);
    chk("R4 stop beats start and tick", rdata, 8'h00);
    chk("R5 strobe with combined write", {7'd0, pout_reset}, 8'h01);
    cyc(0, 8'h00, 1, 0, 0);
    chk("R4 stays idle after tick", rdata, 8'h00);
  endtask

  task automatic t_flags;
    cyc(0, 8'h00, 0, 1, 0);
    chk("R6 edge flag set", rdata, 8'h10);
    cyc(0, 8'h00, 0, 0, 1);
    chk("R7 underflow flag set", rdata, 8'h30);
    for (int i = 0; i < 2; i++) cyc(0, 8'h00, 1, 0, 0);
    chk("R6 R7 flags sticky", rdata, 8'h30);
    cyc(1, 8'h30, 0, 0, 0);
    chk("R8 write 1 keeps flags", rdata, 8'h30);
    cyc(1, 8'h20, 0, 0, 0);
    chk("R8 write 0 clears edge only", rdata, 8'h20);
    cyc(1, 8'h00, 0, 0, 0);
    chk("R8 write 0 clears underflow", rdata, 8'h00);
  endtask

  task automatic t_set_wins;
    cyc(1, 8'h00, 0, 1, 0);
    chk("R9 edge set beats clear", rdata, 8'h10);
    cyc(1, 8'h10, 0, 0, 1);
    chk("R9 underflow set beats clear", rdata, 8'h30);
    cyc(1, 8'h00, 0, 0, 0);
    chk("R8 flags cleared", rdata, 8'h00);
  endtask

  task automatic t_unassigned;
    cyc(1, 8'hCA, 0, 0, 0);
    chk("R10 bits 3,6,7 and R3 bit1 ignore writes", rdata, 8'h00);
    cyc(1, 8'h0B, 0, 0, 0);
    chk("R10 only request stored", rdata, 8'h01);
    cyc(1, 8'h04, 0, 0, 0);
    chk("R4 cleanup", rdata, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_start_stop;
    t_write_with_tick;
    t_force_stop;
    t_flags;
    t_set_wins;
    t_unassigned;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule